// File: doc/BRIEF.md
# Operand Forwarding and Stall Unit

This block resolves read-after-write hazards for the instruction about to enter the execute stage of a five-stage in-order pipeline. It is purely combinational. It compares the source register numbers of that instruction with the destinations of the instructions held in the memory and writeback stage registers. For each source operand it returns a mux select that picks the register file value, the writeback value or the memory-stage ALU result. It also returns one stall request for the whole pipeline.

A two-bit mode input sets how the block behaves. One mode does no hazard checking. One mode stalls on every hazard. One mode forwards wherever it can and stalls only when the value is still being loaded. Separately from the mode, an instruction marked as a control/status register access asks for a stall while the memory stage still holds a valid instruction. This drains older work ahead of it.

Top module: `hz_fwd_unit`

## Requirements
- R1: A stage (memory or writeback) has a hazard with source operand i only when all of the following hold: that stage is valid, it writes a register, its destination is not register 0, the use flag of operand i is 1, and the destination equals source i.
- R2: The mode input encodes 0 = no checks, 1 = stall only, 2 = stall plus forward, and 3 = behaves like 0. Each per-operand select encodes 0 = register file, 1 = writeback value, 2 = memory-stage ALU result.
- R3: In mode 0 or 3, every select is 0 and no hazard causes a stall.
- R4: In mode 1, any hazard on any operand in either stage raises the stall, and every select stays 0.
- R5: In mode 2, a writeback-stage hazard on an operand sets that operand's select to 1, with no stall.
- R6: In mode 2, a memory-stage hazard from a non-load sets the select to 2, with no stall. When both stages match, the memory stage wins.
- R7: In mode 2, a memory-stage hazard from a load raises the stall. The operand's select then shows 1 if the writeback stage also matches, and 0 otherwise.
- R8: A CSR-flagged execute instruction raises the stall in every mode while the memory stage is valid. Without a valid memory stage it does not stall.
- R9: The operands are resolved independently: in one cycle, operand 0 and operand 1 may take different sources.
- R10: The stall output is the OR of the hazard stall and the CSR stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | Hazard handling mode |
| ex_src_i | input | NUM_SRC*REG_W | Source register numbers, operand 0 in the low bits |
| ex_use_i | input | NUM_SRC | Source use flags, bit i for operand i |
| ex_csr_i | input | 1 | Execute instruction is a CSR access |
| mem_valid_i | input | 1 | Memory stage holds a valid instruction |
| mem_wr_i | input | 1 | Memory stage writes a register |
| mem_load_i | input | 1 | Memory stage instruction is a load |
| mem_rd_i | input | REG_W | Memory stage destination register |
| wb_valid_i | input | 1 | Writeback stage holds a valid instruction |
| wb_wr_i | input | 1 | Writeback stage writes a register |
| wb_rd_i | input | REG_W | Writeback stage destination register |
| fwd_sel_o | output | 2*NUM_SRC | Per-operand source select, operand 0 in the low bits |
| stall_o | output | 1 | Stall request |

## Verification
The hardest case to reach from the ports is both stages matching the same operand while the memory-stage instruction is a load. Here the stall and a writeback select must appear together. A second hard case is the two operands resolving to different stages in the same cycle. The vector table builds both directly by setting the two destinations equal to chosen sources with the load flag set. A sweep over every register number also confirms that register 0 is never forwarded.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_WB  = 2'd1,
    SRC_MEM = 2'd2
  } src_sel_e;

  typedef enum logic [1:0] {
    HM_OFF   = 2'd0,
    HM_STALL = 2'd1,
    HM_FWD   = 2'd2,
    HM_RSVD  = 2'd3
  } hz_mode_e;
endpackage

// File: rtl/hz_stage_cmp.sv
module hz_stage_cmp #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                     stg_valid_i,
  input  logic                     stg_wr_i,
  input  logic [REG_W-1:0]         stg_rd_i,
  input  logic [NUM_SRC*REG_W-1:0] src_i,
  input  logic [NUM_SRC-1:0]       use_i,
  output logic [NUM_SRC-1:0]       hit_o
);
  logic writes_real;

  // a stage only counts when it really produces a non-zero destination
  assign writes_real = stg_valid_i && stg_wr_i && (stg_rd_i != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
    assign hit_o[g] = writes_real && use_i[g] &&
                      (src_i[g*REG_W +: REG_W] == stg_rd_i);
  end
endmodule

// File: rtl/hz_src_resolve.sv
module hz_src_resolve
  import hz_pkg::*;
(
  input  hz_mode_e mode_i,
  input  logic     hit_wb_i,
  input  logic     hit_mem_i,
  input  logic     mem_load_i,
  output src_sel_e sel_o,
  output logic     stall_o
);
  always_comb begin
    sel_o   = SRC_RF;
    stall_o = 1'b0;
    unique case (mode_i)
      HM_STALL: stall_o = hit_wb_i || hit_mem_i;
      HM_FWD: begin
        if (hit_wb_i) sel_o = SRC_WB;
        if (hit_mem_i) begin
          if (mem_load_i) stall_o = 1'b1;
          else            sel_o   = SRC_MEM;
        end
      end
      default: begin
        sel_o   = SRC_RF;
        stall_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [1:0]               mode_i,
  input  logic [NUM_SRC*REG_W-1:0] ex_src_i,
  input  logic [NUM_SRC-1:0]       ex_use_i,
  input  logic                     ex_csr_i,
  input  logic                     mem_valid_i,
  input  logic                     mem_wr_i,
  input  logic                     mem_load_i,
  input  logic [REG_W-1:0]         mem_rd_i,
  input  logic                     wb_valid_i,
  input  logic                     wb_wr_i,
  input  logic [REG_W-1:0]         wb_rd_i,
  output logic [SEL_W*NUM_SRC-1:0] fwd_sel_o,
  output logic                     stall_o
);
  logic [NUM_SRC-1:0] hit_mem;
  logic [NUM_SRC-1:0] hit_wb;
  logic [NUM_SRC-1:0] op_stall;
  logic               csr_stall;
  hz_mode_e           mode;

  assign mode = hz_mode_e'(mode_i);

  hz_stage_cmp #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_cmp_mem (
    .stg_valid_i (mem_valid_i),
    .stg_wr_i    (mem_wr_i),
    .stg_rd_i    (mem_rd_i),
    .src_i       (ex_src_i),
    .use_i       (ex_use_i),
    .hit_o       (hit_mem)
  );

  hz_stage_cmp #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_cmp_wb (
    .stg_valid_i (wb_valid_i),
    .stg_wr_i    (wb_wr_i),
    .stg_rd_i    (wb_rd_i),
    .src_i       (ex_src_i),
    .use_i       (ex_use_i),
    .hit_o       (hit_wb)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_res
    src_sel_e sel;
    hz_src_resolve i_res (
      .mode_i     (mode),
      .hit_wb_i   (hit_wb[g]),
      .hit_mem_i  (hit_mem[g]),
      .mem_load_i (mem_load_i),
      .sel_o      (sel),
      .stall_o    (op_stall[g])
    );
    assign fwd_sel_o[g*SEL_W +: SEL_W] = sel;

    always_comb begin
      if (sel == SRC_MEM) begin
        AST_MEM_NOT_LOAD: assert (!mem_load_i && mem_rd_i != '0 &&
          ex_src_i[g*REG_W +: REG_W] == mem_rd_i); // R7
      end
      if (sel == SRC_WB) begin
        AST_WB_NOT_X0: assert (wb_rd_i != '0 && wb_valid_i && wb_wr_i); // R1
      end
      if (mode != HM_FWD) begin
        AST_NO_FWD_OUTSIDE_MODE: assert (sel == SRC_RF); // R3
      end
    end
  end

  // an access to control state waits until the memory stage has drained
  assign csr_stall = ex_csr_i && mem_valid_i;
  assign stall_o   = (|op_stall) || csr_stall;

  always_comb begin
    if (ex_csr_i && mem_valid_i) begin
      AST_CSR_STALLS: assert (stall_o); // R8
    end
    if (mode == HM_STALL && (|(hit_wb | hit_mem))) begin
      AST_STALL_MODE: assert (stall_o); // R4
    end
  end
endmodule

// File: tb/test_hz_fwd_unit.sv
module test_hz_fwd_unit;
  localparam int REG_W   = 5;
  localparam int NUM_SRC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]               mode_i;
  logic [NUM_SRC*REG_W-1:0] ex_src_i;
  logic [NUM_SRC-1:0]       ex_use_i;
  logic                     ex_csr_i, mem_valid_i, mem_wr_i, mem_load_i;
  logic [REG_W-1:0]         mem_rd_i;
  logic                     wb_valid_i, wb_wr_i;
  logic [REG_W-1:0]         wb_rd_i;
  logic [2*NUM_SRC-1:0]     fwd_sel_o;
  logic                     stall_o;

  hz_fwd_unit #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_hz_fwd_unit (
    .mode_i(mode_i), .ex_src_i(ex_src_i), .ex_use_i(ex_use_i), .ex_csr_i(ex_csr_i),
    .mem_valid_i(mem_valid_i), .mem_wr_i(mem_wr_i), .mem_load_i(mem_load_i),
    .mem_rd_i(mem_rd_i), .wb_valid_i(wb_valid_i), .wb_wr_i(wb_wr_i), .wb_rd_i(wb_rd_i),
    .fwd_sel_o(fwd_sel_o), .stall_o(stall_o)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [4:0] s0, s1;
    logic [1:0] use_f;
    logic csr, mv, mw, ml;
    logic [4:0] mrd;
    logic wv, ww;
    logic [4:0] wrd;
    logic [1:0] e0, e1;
    logic est;
  } vec_t;

  localparam int NV = 16;
  // mode  s0 s1 use csr mv mw ml mrd wv ww wrd e0 e1 st
  localparam vec_t VEC [NV] = '{
    '{2'd2, 5'd3, 5'd4, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 5'd3, 1'b1, 1'b1, 5'd4, 2'd2, 2'd1, 1'b0}, // R9 R5 R6
    '{2'd2, 5'd5, 5'd5, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 5'd5, 1'b1, 1'b1, 5'd5, 2'd2, 2'd2, 1'b0}, // R6 priority
    '{2'd2, 5'd5, 5'd6, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 5'd5, 1'b1, 1'b1, 5'd5, 2'd1, 2'd0, 1'b1}, // R7 with wb
    '{2'd2, 5'd5, 5'd6, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 5'd6, 1'b1, 1'b0, 5'd5, 2'd0, 2'd0, 1'b1}, // R7 alone
    '{2'd1, 5'd7, 5'd1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 5'd7, 2'd0, 2'd0, 1'b1}, // R4 wb
    '{2'd1, 5'd2, 5'd8, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 5'd8, 1'b0, 1'b0, 5'd0, 2'd0, 2'd0, 1'b1}, // R4 mem
    '{2'd0, 5'd2, 5'd8, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 5'd8, 1'b1, 1'b1, 5'd2, 2'd0, 2'd0, 1'b0}, // R3 off
    '{2'd3, 5'd2, 5'd8, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 5'd8, 1'b1, 1'b1, 5'd2, 2'd0, 2'd0, 1'b0}, // R2 mode 3
    '{2'd2, 5'd0, 5'd0, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0, 1'b1, 1'b1, 5'd0, 2'd0, 2'd0, 1'b0}, // R1 x0
    '{2'd2, 5'd9, 5'd9, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 5'd9, 1'b1, 1'b1, 5'd9, 2'd0, 2'd0, 1'b0}, // R1 no use
    '{2'd2, 5'd9, 5'd1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd9, 2'd0, 2'd0, 1'b0}, // R1 wb invalid
    '{2'd2, 5'd9, 5'd1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 5'd9, 1'b0, 1'b0, 5'd0, 2'd0, 2'd0, 1'b0}, // R1 mem no write
    '{2'd0, 5'd1, 5'd2, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 2'd0, 2'd0, 1'b1}, // R8 off mode
    '{2'd2, 5'd1, 5'd2, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 2'd0, 2'd0, 1'b0}, // R8 drained
    '{2'd2, 5'd3, 5'd2, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 5'd3, 2'd1, 2'd0, 1'b1}, // R10
    '{2'd2, 5'd4, 5'd4, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 5'd4, 1'b0, 1'b0, 5'd0, 2'd2, 2'd0, 1'b0}  // R9 use mask
  };

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    mode_i = v.mode; ex_src_i = {v.s1, v.s0}; ex_use_i = v.use_f; ex_csr_i = v.csr;
    mem_valid_i = v.mv; mem_wr_i = v.mw; mem_load_i = v.ml; mem_rd_i = v.mrd;
    wb_valid_i = v.wv; wb_wr_i = v.ww; wb_rd_i = v.wrd;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t z;
    z = '0;
    drive(z);
    // reset state: idle inputs give register-file selects and no stall (R2)
    check("R2 reset sel", fwd_sel_o, 0);
    check("R10 reset stall", stall_o, 0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k]);
      check($sformatf("R5/R6/R7 vec%0d sel0", k), fwd_sel_o[1:0], VEC[k].e0);
      check($sformatf("R9 vec%0d sel1", k), fwd_sel_o[3:2], VEC[k].e1);
      check($sformatf("R10 vec%0d stall", k), stall_o, VEC[k].est);
    end

    // R1 sweep: writeback forwarding for every register, never for register 0
    for (int r = 0; r < 32; r++) begin
      vec_t v;
      v = '0;
      v.mode = 2'd2; v.s0 = 5'(r); v.s1 = 5'(r); v.use_f = 2'b11;
      v.wv = 1'b1; v.ww = 1'b1; v.wrd = 5'(r);
      drive(v);
      check($sformatf("R1 sweep r%0d", r), fwd_sel_o, (r != 0) ? 5 : 0);
      check($sformatf("R5 sweep r%0d stall", r), stall_o, 0);
    end

    // R6 sweep: memory forwarding wins over writeback for every non-zero register
    for (int r = 1; r < 32; r++) begin
      vec_t v;
      v = '0;
      v.mode = 2'd2; v.s0 = 5'(r); v.use_f = 2'b01;
      v.mv = 1'b1; v.mw = 1'b1; v.mrd = 5'(r);
      v.wv = 1'b1; v.ww = 1'b1; v.wrd = 5'(r);
      drive(v);
      check($sformatf("R6 sweep r%0d", r), fwd_sel_o, 2);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule